// File: doc/BRIEF.md
# Configurable Serial CRC Checker

This block checks a CRC over a serial bit stream, one bit per clock at most. A field opens with a start strobe, which loads a 16-bit seed into the CRC register and latches the polynomial configuration. Data bits arrive with a data strobe and advance the shift register most significant bit first. The received CRC bits follow with their own strobe and are collected into a separate register. An end strobe closes the field, and one cycle later the block reports whether the received CRC equals the bitwise inverse of the computed one.

A 7-bit configuration field is read in one of two ways, chosen by a select input. It is either a CRC length that picks a built-in default polynomial, or it is the polynomial itself written out in full. The same module serves the data-channel CRC of up to 17 bits and, as a second instance, the 4-bit control-frame CRC. Each accepted bit is also forwarded to the receive buffer. A no-store option keeps the received CRC bits out of that buffer stream.

Top module: `crc_serial_chk`

## Requirements
- R1: While rst_ni is low and after its release, done_o, ok_o and err_o are 0, and no field is open.
- R2: With sel_poly_i=0, cfg_field_i is a length L that selects a default polynomial (the leading term x^L is implied): 4 gives x^4+x+1, 5 gives x^5+x^2+1, 6 gives x^6+x+1, 7 gives x^7+x^3+1, 8 gives x^8+x^2+x+1, 16 gives x^16+x^12+x^5+1, 17 gives x^17+x^3+1. Any other length gives err_o=1 at the end of the field.
- R3: With sel_poly_i=1, cfg_field_i is the whole polynomial: bit i is the coefficient of x^i, and the highest set bit gives the width L. A field value of 0 or 1 gives err_o=1 at the end of the field.
- R4: start_i loads the low L bits of seed_i into the CRC register. Bits of the register above bit 15 start at 0.
- R5: The register moves only on an accepted data bit. With feedback f = reg[L-1] xor bit_i, it is shifted left by one, XORed with the polynomial's low terms when f=1, and kept to L bits. Idle cycles between data bits leave it unchanged.
- R6: Received CRC bits come in most significant bit first. The check passes only when exactly L of them arrived and they equal the bitwise inverse of the final register. Otherwise err_o=1.
- R7: done_o is a single-cycle pulse in the cycle after end_i is accepted. Exactly one of ok_o and err_o is 1 with that pulse. Both hold until the next start_i, which clears them at once.
- R8: store_vld_o is 1 for each accepted data bit, and for each accepted CRC bit when no_store_i=0. store_bit_o equals bit_i. With no_store_i=1, accepted CRC bits leave store_vld_o at 0.
- R9: sel_poly_i, cfg_field_i and seed_i are sampled only with start_i. Changes during the field have no effect on the result.
- R10: Strobes are ignored outside an open field and in the start_i and end_i cycles. When data_vld_i and crc_vld_i are both 1, the bit is taken as data only. start_i wins over end_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a field: loads the seed and latches the configuration |
| sel_poly_i | input | 1 | 0: field is a length code; 1: field is the polynomial |
| cfg_field_i | input | 7 | Length code or polynomial |
| seed_i | input | 16 | CRC start value |
| no_store_i | input | 1 | Keeps received CRC bits out of the store stream |
| bit_i | input | 1 | Serial bit |
| data_vld_i | input | 1 | bit_i is a data bit |
| crc_vld_i | input | 1 | bit_i is a received CRC bit |
| end_i | input | 1 | Closes the field and requests the verdict |
| store_vld_o | output | 1 | Bit forwarded to the receive buffer |
| store_bit_o | output | 1 | Forwarded bit value |
| done_o | output | 1 | Verdict pulse |
| ok_o | output | 1 | CRC matched (held) |
| err_o | output | 1 | Mismatch or bad configuration (held) |

## Verification
The bench aims at the edges of the width decode. It runs every default length, including 17 bits where the seed's top bit is forced to 0, and random full polynomials. A mask error would show up there as mismatches on valid streams. It sends streams with one CRC bit flipped, one CRC bit short, one extra CRC bit, and a wrong seed. A compare that checked only the value, or that skipped the inversion, would pass some of these. It also changes the configuration during a field, lets the two strobes overlap, sends strobes while no field is open, and inserts gaps between data bits. A design that sampled its configuration late, counted an overlapped bit twice, or shifted on idle cycles would then report the wrong verdict. Finally it checks store_vld_o on every bit with no_store_i set and cleared.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;
  localparam int TBL_W = 17;

  // {hit, poly low terms}; leading term implied by length
  function automatic logic [TBL_W:0] default_poly(input logic [6:0] len);
    case (len)
      7'd4:    default_poly = {1'b1, 17'h00003};
      7'd5:    default_poly = {1'b1, 17'h00005};
      7'd6:    default_poly = {1'b1, 17'h00003};
      7'd7:    default_poly = {1'b1, 17'h00009};
      7'd8:    default_poly = {1'b1, 17'h00007};
      7'd16:   default_poly = {1'b1, 17'h01021};
      7'd17:   default_poly = {1'b1, 17'h00009};
      default: default_poly = '0;
    endcase
  endfunction
endpackage

// File: rtl/crc_poly_dec.sv
module crc_poly_dec #(
  parameter int MAX_W = 17,
  parameter int CFG_W = 7,
  localparam int LEN_W = $clog2(MAX_W + 1)
) (
  input  logic             sel_poly_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [LEN_W-1:0] len_o,
  output logic [MAX_W-1:0] poly_o,
  output logic             err_o
);
  logic [crc_chk_pkg::TBL_W:0] tbl;
  int unsigned deg;

  assign tbl = crc_chk_pkg::default_poly(7'(cfg_i));

  always_comb begin
    len_o  = LEN_W'(1);
    poly_o = MAX_W'(1);
    err_o  = 1'b1;
    deg    = 0;
    if (!sel_poly_i) begin
      if (tbl[crc_chk_pkg::TBL_W] && (int'(cfg_i) <= MAX_W)) begin
        len_o  = LEN_W'(cfg_i);
        poly_o = MAX_W'(tbl[crc_chk_pkg::TBL_W-1:0]);
        err_o  = 1'b0;
      end
    end else begin
      for (int i = 0; i < CFG_W; i++) begin
        if (cfg_i[i]) deg = i;
      end
      if (deg >= 1 && deg <= MAX_W) begin
        len_o  = LEN_W'(deg);
        poly_o = MAX_W'(cfg_i & ~(CFG_W'(1) << deg));
        err_o  = 1'b0;
      end
    end
  end
endmodule

// File: rtl/crc_shift_reg.sv
module crc_shift_reg #(
  parameter int MAX_W  = 17,
  parameter int SEED_W = 16,
  localparam int LEN_W = $clog2(MAX_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SEED_W-1:0] seed_i,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [MAX_W-1:0]  poly_i,
  output logic [MAX_W-1:0]  crc_o
);
  logic [MAX_W-1:0] mask, crc_q, crc_nxt;
  logic             fb;

  for (genvar g = 0; g < MAX_W; g++) begin : g_mask
    assign mask[g] = (g < int'(len_i));
  end

  // bit L-1 of the register, picked by the mask edge
  assign fb      = (|(crc_q & mask & ~(mask >> 1))) ^ bit_i;
  assign crc_nxt = ((crc_q << 1) ^ (fb ? poly_i : '0)) & mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (load_i)  crc_q <= MAX_W'(seed_i) & mask;
    else if (shift_i) crc_q <= crc_nxt;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/crc_rx_cmp.sv
module crc_rx_cmp #(
  parameter int MAX_W = 17,
  localparam int LEN_W = $clog2(MAX_W + 1),
  localparam int CNT_W = LEN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             shift_i,
  input  logic             bit_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [MAX_W-1:0] crc_i,
  output logic             match_o
);
  logic [MAX_W-1:0] mask, rx_q;
  logic [CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < MAX_W; g++) begin : g_mask
    assign mask[g] = (g < int'(len_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      rx_q  <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      rx_q <= {rx_q[MAX_W-2:0], bit_i};
      if (cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign match_o = (cnt_q == CNT_W'(len_i)) && ((rx_q & mask) == (~crc_i & mask));
endmodule

// File: rtl/crc_serial_chk.sv
module crc_serial_chk #(
  parameter int MAX_W  = 17,
  parameter int SEED_W = 16,
  parameter int CFG_W  = 7,
  localparam int LEN_W = $clog2(MAX_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sel_poly_i,
  input  logic [CFG_W-1:0]  cfg_field_i,
  input  logic [SEED_W-1:0] seed_i,
  input  logic              no_store_i,
  input  logic              bit_i,
  input  logic              data_vld_i,
  input  logic              crc_vld_i,
  input  logic              end_i,
  output logic              store_vld_o,
  output logic              store_bit_o,
  output logic              done_o,
  output logic              ok_o,
  output logic              err_o
);
  logic [LEN_W-1:0] dec_len, len_q, len_use;
  logic [MAX_W-1:0] dec_poly, poly_q, poly_use, crc;
  logic             dec_err, cfg_err_q, active_q, done_q, ok_q, err_q;
  logic             data_shift, crc_shift, match;

  crc_poly_dec #(.MAX_W(MAX_W), .CFG_W(CFG_W)) u_dec (
    .sel_poly_i(sel_poly_i), .cfg_i(cfg_field_i),
    .len_o(dec_len), .poly_o(dec_poly), .err_o(dec_err)
  );

  // decoded config applies in the start cycle, latched copy afterwards
  assign len_use  = start_i ? dec_len  : len_q;
  assign poly_use = start_i ? dec_poly : poly_q;

  assign data_shift = active_q && data_vld_i && !start_i && !end_i;
  assign crc_shift  = active_q && crc_vld_i && !data_vld_i && !start_i && !end_i;

  crc_shift_reg #(.MAX_W(MAX_W), .SEED_W(SEED_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(start_i), .seed_i(seed_i),
    .shift_i(data_shift), .bit_i(bit_i), .len_i(len_use), .poly_i(poly_use),
    .crc_o(crc)
  );

  crc_rx_cmp #(.MAX_W(MAX_W)) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(start_i), .shift_i(crc_shift),
    .bit_i(bit_i), .len_i(len_use), .crc_i(crc), .match_o(match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      len_q     <= LEN_W'(1);
      poly_q    <= MAX_W'(1);
      cfg_err_q <= 1'b0;
      done_q    <= 1'b0;
      ok_q      <= 1'b0;
      err_q     <= 1'b0;
    end else if (start_i) begin
      active_q  <= 1'b1;
      len_q     <= dec_len;
      poly_q    <= dec_poly;
      cfg_err_q <= dec_err;
      done_q    <= 1'b0;
      ok_q      <= 1'b0;
      err_q     <= 1'b0;
    end else if (active_q && end_i) begin
      active_q <= 1'b0;
      done_q   <= 1'b1;
      ok_q     <= match && !cfg_err_q;
      err_q    <= !(match && !cfg_err_q);
    end else begin
      done_q <= 1'b0;
    end
  end

  assign store_vld_o = data_shift || (crc_shift && !no_store_i);
  assign store_bit_o = bit_i;
  assign done_o      = done_q;
  assign ok_o        = ok_q;
  assign err_o       = err_q;
endmodule

// File: rtl/crc_serial_chk_chk.sv
module crc_serial_chk_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic end_i,
  input logic data_vld_i,
  input logic crc_vld_i,
  input logic no_store_i,
  input logic store_vld_o,
  input logic done_o,
  input logic ok_o,
  input logic err_o
);
  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      reset_idle_chk: assert (!done_o && !ok_o && !err_o);
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(end_i) && !$past(start_i));

  // R6
  verdict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ok_o != err_o));

  // R7
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!ok_o && !err_o && !done_o));

  // R7
  ok_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_o && !start_i) |=> ok_o);

  // R7
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> err_o);

  // R8
  no_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crc_vld_i && !data_vld_i && no_store_i) |-> !store_vld_o);

  // R10
  store_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_vld_o |-> ((data_vld_i || crc_vld_i) && !start_i && !end_i));
endmodule

bind crc_serial_chk crc_serial_chk_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .end_i(end_i),
  .data_vld_i(data_vld_i), .crc_vld_i(crc_vld_i), .no_store_i(no_store_i),
  .store_vld_o(store_vld_o), .done_o(done_o), .ok_o(ok_o), .err_o(err_o)
);

// File: tb/crc_serial_chk_bench.sv
module crc_serial_chk_bench;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic start, sel, no_store, bit_v, dvld, cvld, endf;
  logic [6:0] cfg;
  logic [15:0] seed;
  logic store_vld, store_bit, done, ok, err;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  crc_serial_chk u_crc_serial_chk (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .sel_poly_i(sel),
    .cfg_field_i(cfg), .seed_i(seed), .no_store_i(no_store), .bit_i(bit_v),
    .data_vld_i(dvld), .crc_vld_i(cvld), .end_i(endf),
    .store_vld_o(store_vld), .store_bit_o(store_bit),
    .done_o(done), .ok_o(ok), .err_o(err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // decode per R2/R3
  task automatic ref_dec(input logic s, input logic [6:0] f, output int len,
                         output logic [16:0] p, output bit bad);
    bad = 1; len = 1; p = 17'h1;
    if (!s) begin
      bad = 0; len = int'(f);
      case (f)
        7'd4: p = 17'h3;  7'd5: p = 17'h5;  7'd6: p = 17'h3;  7'd7: p = 17'h9;
        7'd8: p = 17'h7;  7'd16: p = 17'h1021; 7'd17: p = 17'h9;
        default: begin bad = 1; len = 1; end
      endcase
    end else begin
      int d = 0;
      for (int i = 0; i < 7; i++) if (f[i]) d = i;
      if (d >= 1) begin bad = 0; len = d; p = 17'(f) & ~(17'h1 << d); end
    end
  endtask

  function automatic logic [16:0] ref_crc(input logic [16:0] p, input int len,
      input logic [15:0] sd, input logic [63:0] d, input int n);
    logic [17:0] m = (18'h1 << len) - 18'h1;
    logic [16:0] c = {1'b0, sd} & m[16:0];
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = c[len-1] ^ d[i];
      c = ((c << 1) ^ (fb ? p : 17'h0)) & m[16:0];
    end
    return c;
  endfunction

  task automatic idle_inputs();
    start = 0; bit_v = 0; dvld = 0; cvld = 0; endf = 0;
  endtask

  // mode: 0 good, 1 flip a crc bit, 2 one crc bit short, 3 one extra, 4 wrong seed
  task automatic run_field(input string tag, input logic s, input logic [6:0] f,
      input logic [15:0] sd, input int n, input logic [63:0] d, input int mode,
      input bit ns, input bit junk, input bit overlap, input bit gaps);
    int len; logic [16:0] p, c; bit bad; int ncrc;
    ref_dec(s, f, len, p, bad);
    c = ~ref_crc(p, len, (mode == 4) ? (sd ^ 16'h1) : sd, d, n);
    if (mode == 1) c[0] = ~c[0];
    ncrc = len + ((mode == 2) ? -1 : (mode == 3) ? 1 : 0);
    @(negedge clk);
    idle_inputs(); start = 1; sel = s; cfg = f; seed = sd; no_store = ns;
    @(negedge clk);
    start = 0;
    check({tag, " R7 start clears ok"}, ok, 0);
    check({tag, " R7 start clears err"}, err, 0);
    if (junk) begin sel = ~s; cfg = 7'($urandom); seed = 16'($urandom); end // R9
    for (int i = n - 1; i >= 0; i--) begin
      if (gaps && ($urandom_range(0, 2) == 0)) begin // R5 idle gap
        dvld = 0; cvld = 0; bit_v = 1'($urandom);
        @(negedge clk);
      end
      dvld = 1; bit_v = d[i];
      cvld = overlap && (i == n / 2); // R10 overlap taken as data
      #1 check({tag, " R8 data store"}, {store_vld, store_bit}, {1'b1, d[i]});
      @(negedge clk);
    end
    dvld = 0;
    for (int i = len - 1; i >= len - ncrc; i--) begin
      cvld = 1; bit_v = (i >= 0) ? c[i] : 1'($urandom);
      #1 check({tag, " R8 crc store"}, store_vld, !ns);
      @(negedge clk);
    end
    cvld = 0; endf = 1; bit_v = 1; dvld = 1; // R10 end cycle strobes ignored
    #1 check({tag, " R10 end cycle no store"}, store_vld, 0);
    @(negedge clk);
    idle_inputs();
    check({tag, " R7 done"}, done, 1);
    check({tag, " R6 ok"}, ok, !bad && mode == 0);
    check({tag, " R6 err"}, err, bad || mode != 0);
    @(negedge clk);
    check({tag, " R7 done pulse ends"}, done, 0);
    check({tag, " R7 ok held"}, ok, !bad && mode == 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [6:0] dl [7] = '{7'd4, 7'd5, 7'd6, 7'd7, 7'd8, 7'd16, 7'd17};
    void'($urandom(32'h5eed));
    idle_inputs(); sel = 0; cfg = 0; seed = 0; no_store = 0;
    repeat (3) @(negedge clk);
    check("R1 reset done", done, 0);
    check("R1 reset ok", ok, 0);
    check("R1 reset err", err, 0);
    rst_ni = 1;
    @(negedge clk);
    check("R1 post reset done", done, 0);
    // R10 strobes with no open field
    dvld = 1; cvld = 1; bit_v = 1; endf = 1;
    #1 check("R10 idle no store", store_vld, 0);
    @(negedge clk);
    check("R10 idle end no done", done, 0);
    idle_inputs();
    // R2 length 6 directed
    run_field("R2 len6", 0, 7'd6, 16'h0015, 8, 64'hA5, 0, 0, 0, 0, 0);
    // R2 every default length
    foreach (dl[k])
      run_field("R2 deflen", 0, dl[k], 16'($urandom), 24, {$urandom, $urandom}, 0, 0, 0, 0, 0);
    run_field("R2 len17 seed", 0, 7'd17, 16'hFFFF, 40, {$urandom, $urandom}, 0, 0, 0, 0, 0);
    run_field("R2 bad len9", 0, 7'd9, 16'h0, 8, 64'h3C, 0, 0, 0, 0, 0);
    run_field("R2 bad len0", 0, 7'd0, 16'h0, 8, 64'h3C, 0, 0, 0, 0, 0);
    // R3 polynomial mode
    run_field("R3 poly0", 1, 7'd0, 16'h0, 8, 64'h3C, 0, 0, 0, 0, 0);
    run_field("R3 poly1", 1, 7'd1, 16'h0, 8, 64'h3C, 0, 0, 0, 0, 0);
    run_field("R3 poly x^4+x+1", 1, 7'h13, 16'h000A, 16, 64'hBEEF, 0, 0, 0, 0, 0);
    run_field("R3 poly deg1", 1, 7'h3, 16'h1, 5, 64'h15, 0, 0, 0, 0, 0);
    // R4 seed mismatch
    run_field("R4 wrong seed", 0, 7'd8, 16'h00C3, 16, 64'h1234, 4, 0, 0, 0, 0);
    // R6 corruptions
    run_field("R6 flip", 0, 7'd16, 16'hACE1, 32, 64'hDEADBEEF, 1, 0, 0, 0, 0);
    run_field("R6 short", 0, 7'd5, 16'h1F, 12, 64'hABC, 2, 0, 0, 0, 0);
    run_field("R6 extra", 0, 7'd4, 16'h0, 12, 64'h5A5, 3, 0, 0, 0, 0);
    // R8 no-store on
    run_field("R8 nostore", 0, 7'd6, 16'h2A, 10, 64'h2F1, 0, 1, 0, 0, 0);
    // R9 config changes mid-field
    run_field("R9 junk", 0, 7'd7, 16'h55, 20, 64'hF0F0F, 0, 0, 1, 0, 0);
    // R10 overlap, R5 gaps
    run_field("R10 overlap", 1, 7'h25, 16'h7, 18, 64'h2ABCD, 0, 0, 0, 1, 0);
    run_field("R5 gaps", 0, 7'd17, 16'h1357, 30, 64'h2468ACE, 0, 0, 0, 0, 1);
    // random mix
    for (int r = 0; r < 40; r++) begin
      logic s = 1'($urandom);
      logic [6:0] f = s ? 7'($urandom_range(2, 127)) : dl[$urandom_range(0, 6)];
      run_field("R5 random", s, f, 16'($urandom), $urandom_range(1, 64),
                {$urandom, $urandom}, ($urandom_range(0, 3) == 0) ? 1 : 0,
                1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule